// File: doc/BRIEF.md
# DMA Packet Size Divisor Finder

This block turns an audio transfer period into the synchronisation setup that a DMA channel and its FIFO use. It takes the period length in bytes, a sample format code, a threshold-mode enable and the largest FIFO threshold allowed. From these it works out the period length in words. It then chooses one of three synchronisation modes:

- **Per-element**: used when threshold mode is off.
- **Whole-period**: used when the period fits under the threshold.
- **Packet**: used when the period is larger than the threshold. The period is split into equal packets, and each packet is no larger than the threshold.

The packet size comes from a search that tries one candidate divider per clock. The search starts at the ceiling of period/threshold and counts upward. It stops at the first divider that splits the period evenly, which gives the largest packet that fits. When the search reaches the period length itself, no usable split exists and the block reports an error.

A caller pulses `start_i` while the block is idle. The block raises `busy_o` while it works. It then presents the result with a one-cycle `done_o` pulse and holds the result until the next request finishes.

Top module: `dma_pkt_split`

## Requirements
- R1: The request inputs are captured only on a clock where `start_i` is high and the block is idle. A `start_i` or input change while `busy_o` is high has no effect on the result.
- R2: The format code selects the word size:
  - `fmt_i` = 0 selects 16-bit words, and words = floor(bytes/2).
  - `fmt_i` = 1 selects 32-bit words, and words = floor(bytes/4).
  - Codes 2 and 3 give an error result. This check takes priority over all others.
- R3: When threshold mode is off (`thr_mode_i` = 0), the result is mode 0 (element). `thr_o` is 1 and `pkt_size_o` is 0.
- R4: With threshold mode on and words <= max threshold, the result is mode 1 (frame). `thr_o` equals the word count and `pkt_size_o` is 0. This includes zero words.
- R5: With words > max threshold >= 1, the search starts at divider ceil(words/max) and tests one candidate per clock. `busy_o` stays high for 1 + n cycles, where n is the number of candidates tested.
- R6: When the search succeeds, the result is mode 2 (packet). Both `pkt_size_o` and `thr_o` equal words/divider, using the first divider that leaves no remainder. The packet size is never above the max threshold.
- R7: If the candidate divider reaches the word count, the result is an error: `err_o` = 1, mode 3 (none), and `pkt_size_o` and `thr_o` both 0.
- R8: With threshold mode on, max threshold 0 and a nonzero word count, the result is an error.
- R9: `busy_o` rises on the clock after `start_i` is accepted. It lasts one cycle for non-search outcomes. `done_o` is a single-cycle pulse in the cycle right after `busy_o` falls, and it is never high together with `busy_o`.
- R10: After reset, `busy_o`, `done_o` and `err_o` are 0, mode is 0, and `pkt_size_o` and `thr_o` are 0. Result outputs change only in a cycle where `done_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request strobe, accepted while idle |
| fmt_i | input | 2 | Sample format: 0 = 16-bit, 1 = 32-bit, others invalid |
| thr_mode_i | input | 1 | Threshold mode enable |
| period_bytes_i | input | WORD_W+1 | Period length in bytes |
| max_thr_i | input | WORD_W | Largest FIFO threshold in words |
| busy_o | output | 1 | Request in progress |
| done_o | output | 1 | One-cycle result strobe |
| err_o | output | 1 | No valid setup for the request |
| mode_o | output | 2 | 0 element, 1 frame, 2 packet, 3 none |
| pkt_size_o | output | WORD_W | Packet size in words (packet mode only) |
| thr_o | output | WORD_W | FIFO threshold to program |

## Verification
The bench builds the block with WORD_W = 10, which makes the period field 11 bits wide. At this width the largest word counts (1023 and 511) can be used as test inputs. A near-worst search, a 1021-word prime period against a threshold of 2, fits in about five hundred cycles. This allows the bench to exercise exhausted searches, long candidate walks and the frame/packet boundary where words equal the threshold. A sweep over small periods and thresholds also checks the per-cycle busy length against a behavioural search model.

// File: rtl/psz_pkg.sv
package psz_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_CLASS  = 2'd1,
    ST_SEARCH = 2'd2
  } psz_state_e;

  localparam logic [1:0] MODE_ELEM  = 2'd0;
  localparam logic [1:0] MODE_FRAME = 2'd1;
  localparam logic [1:0] MODE_PKT   = 2'd2;
  localparam logic [1:0] MODE_NONE  = 2'd3;

  localparam logic [1:0] FMT_W16 = 2'd0;
  localparam logic [1:0] FMT_W32 = 2'd1;
endpackage

// File: rtl/psz_word_count.sv
module psz_word_count
  import psz_pkg::*;
#(
  parameter int unsigned WORD_W = 16
) (
  input  logic [WORD_W:0]   bytes_i,
  input  logic [1:0]        fmt_i,
  output logic [WORD_W-1:0] words_o,
  output logic              fmt_ok_o
);
  logic [WORD_W:0] shifted;
  logic            unused_msb;

  always_comb begin
    case (fmt_i)
      FMT_W16: shifted = bytes_i >> 1;
      FMT_W32: shifted = bytes_i >> 2;
      default: shifted = '0;
    endcase
  end

  assign words_o    = shifted[WORD_W-1:0];
  assign unused_msb = shifted[WORD_W];
  assign fmt_ok_o   = (fmt_i == FMT_W16) || (fmt_i == FMT_W32);
endmodule

// File: rtl/psz_restoring_div.sv
module psz_restoring_div #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] dividend_i,
  input  logic [W-1:0] divisor_i,
  output logic [W-1:0] quot_o,
  output logic [W-1:0] rem_o
);
  logic [W-1:0] part [0:W];

  assign part[0] = '0;

  for (genvar i = 0; i < W; i++) begin : g_stage
    logic [W:0] trial;
    logic       ge;
    assign trial = {part[i], dividend_i[W-1-i]};
    assign ge    = trial >= {1'b0, divisor_i};
    assign part[i+1]     = ge ? W'(trial - {1'b0, divisor_i}) : trial[W-1:0];
    assign quot_o[W-1-i] = ge;
  end

  assign rem_o = part[W];
endmodule

// File: rtl/dma_pkt_split.sv
module dma_pkt_split
  import psz_pkg::*;
#(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [1:0]        fmt_i,
  input  logic              thr_mode_i,
  input  logic [WORD_W:0]   period_bytes_i,
  input  logic [WORD_W-1:0] max_thr_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic [1:0]        mode_o,
  output logic [WORD_W-1:0] pkt_size_o,
  output logic [WORD_W-1:0] thr_o
);
  localparam logic [WORD_W-1:0] ONE = WORD_W'(1);

  psz_state_e state_q, state_d;

  logic [WORD_W-1:0] words_in, words_q, max_q, cand_q, cand_d;
  logic              fmt_ok_in, fmt_ok_q, thr_en_q;
  logic [WORD_W-1:0] dvsr, quot, rem;

  logic              fin, fin_err;
  logic [1:0]        fin_mode;
  logic [WORD_W-1:0] fin_pkt, fin_thr;

  logic              done_q, err_q;
  logic [1:0]        mode_q;
  logic [WORD_W-1:0] pkt_q, thr_q;

  psz_word_count #(.WORD_W(WORD_W)) i_word_count (
    .bytes_i  (period_bytes_i),
    .fmt_i    (fmt_i),
    .words_o  (words_in),
    .fmt_ok_o (fmt_ok_in)
  );

  // one shared divider: threshold during classification, candidate during search
  assign dvsr = (state_q == ST_CLASS) ? max_q : cand_q;

  psz_restoring_div #(.W(WORD_W)) i_div (
    .dividend_i (words_q),
    .divisor_i  (dvsr),
    .quot_o     (quot),
    .rem_o      (rem)
  );

  always_comb begin
    state_d  = state_q;
    cand_d   = cand_q;
    fin      = 1'b0;
    fin_err  = 1'b0;
    fin_mode = MODE_NONE;
    fin_pkt  = '0;
    fin_thr  = '0;
    case (state_q)
      ST_IDLE: if (start_i) state_d = ST_CLASS;
      ST_CLASS: begin
        if (!fmt_ok_q) begin
          fin = 1'b1; fin_err = 1'b1;
        end else if (!thr_en_q) begin
          fin = 1'b1; fin_mode = MODE_ELEM; fin_thr = ONE;
        end else if (words_q <= max_q) begin
          fin = 1'b1; fin_mode = MODE_FRAME; fin_thr = words_q;
        end else if (max_q == '0) begin
          fin = 1'b1; fin_err = 1'b1;
        end else begin
          state_d = ST_SEARCH;
          cand_d  = quot + WORD_W'(rem != '0);
        end
      end
      ST_SEARCH: begin
        if (cand_q >= words_q) begin
          fin = 1'b1; fin_err = 1'b1;
        end else if (rem == '0) begin
          fin = 1'b1; fin_mode = MODE_PKT; fin_pkt = quot; fin_thr = quot;
        end else begin
          cand_d = cand_q + ONE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
    if (fin) state_d = ST_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      words_q  <= '0;
      max_q    <= '0;
      fmt_ok_q <= 1'b0;
      thr_en_q <= 1'b0;
      cand_q   <= '0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
      mode_q   <= MODE_ELEM;
      pkt_q    <= '0;
      thr_q    <= '0;
    end else begin
      state_q <= state_d;
      cand_q  <= cand_d;
      done_q  <= fin;
      if (state_q == ST_IDLE && start_i) begin
        words_q  <= words_in;
        max_q    <= max_thr_i;
        fmt_ok_q <= fmt_ok_in;
        thr_en_q <= thr_mode_i;
      end
      if (fin) begin
        err_q  <= fin_err;
        mode_q <= fin_mode;
        pkt_q  <= fin_pkt;
        thr_q  <= fin_thr;
      end
    end
  end

  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = done_q;
  assign err_o      = err_q;
  assign mode_o     = mode_q;
  assign pkt_size_o = pkt_q;
  assign thr_o      = thr_q;

  a_r1_hold_request: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(words_q) && $stable(max_q) && $stable(thr_en_q) && $stable(fmt_ok_q));

  a_r5_one_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SEARCH) |=> (state_q != ST_SEARCH) || (cand_q == $past(cand_q) + ONE));

  a_r6_pkt_fits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && mode_o == MODE_PKT) |-> (pkt_size_o != '0) && (pkt_size_o <= max_q) && (thr_o == pkt_size_o));

  a_r4_frame_fits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && mode_o == MODE_FRAME) |-> (thr_o <= max_q) && (pkt_size_o == '0));

  a_r7_err_clean: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && err_o) |-> (mode_o == MODE_NONE) && (pkt_size_o == '0) && (thr_o == '0));

  a_r9_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r9_no_overlap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && busy_o));

  a_r10_result_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(mode_o) && $stable(pkt_size_o) && $stable(thr_o) && $stable(err_o));
endmodule

// File: tb/test_dma_pkt_split.sv
module test_dma_pkt_split;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int unsigned WORD_W = 10;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic [1:0]        fmt = 2'd0;
  logic              thr_mode = 1'b0;
  logic [WORD_W:0]   bytes = '0;
  logic [WORD_W-1:0] max_thr = '0;
  logic              busy, done, err;
  logic [1:0]        mode;
  logic [WORD_W-1:0] pkt, thr;

  int vectors = 0;
  int miscompares = 0;

  always #5 clk = ~clk;

  dma_pkt_split #(.WORD_W(WORD_W)) i_dma_pkt_split (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .fmt_i(fmt),
    .thr_mode_i(thr_mode), .period_bytes_i(bytes), .max_thr_i(max_thr),
    .busy_o(busy), .done_o(done), .err_o(err), .mode_o(mode),
    .pkt_size_o(pkt), .thr_o(thr)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // behavioural model of the request: result fields, busy length and requirement tag
  task automatic model(input int f, input bit tm, input int b, input int mx,
                       output int e_mode, output int e_pkt, output int e_thr,
                       output int e_err, output int e_lat, output string tag);
    int w, d, n;
    e_mode = 3; e_pkt = 0; e_thr = 0; e_err = 0; e_lat = 1;
    if (f > 1) begin
      e_err = 1; tag = "R2"; return;
    end
    w = (f == 0) ? b / 2 : b / 4;
    if (!tm) begin
      e_mode = 0; e_thr = 1; tag = "R3";
    end else if (w <= mx) begin
      e_mode = 1; e_thr = w; tag = "R4";
    end else if (mx == 0) begin
      e_err = 1; tag = "R8";
    end else begin
      d = (w + mx - 1) / mx;
      n = 1;
      while ((w % d) != 0 && d < w) begin
        d++; n++;
      end
      e_lat = 1 + n;
      if (d == w) begin
        e_err = 1; tag = "R7";
      end else begin
        e_mode = 2; e_pkt = w / d; e_thr = w / d; tag = "R6";
      end
    end
  endtask

  task automatic run_case(input int f, input bit tm, input int b, input int mx, input bit junk);
    int e_mode, e_pkt, e_thr, e_err, e_lat;
    string tag, ltag;
    model(f, tm, b, mx, e_mode, e_pkt, e_thr, e_err, e_lat, tag);
    ltag = (e_lat > 1) ? "R5" : "R9";
    if (junk) tag = "R1";
    @(negedge clk);
    fmt = 2'(f); thr_mode = tm; bytes = (WORD_W+1)'(b); max_thr = WORD_W'(mx); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (junk) begin
      start = 1'b1; fmt = 2'd1; thr_mode = ~tm; bytes = ~bytes; max_thr = ~max_thr;
    end
    for (int c = 0; c < e_lat; c++) begin
      chk(busy === 1'b1 && done === 1'b0, ltag, int'(busy), 1);
      @(negedge clk);
      start = 1'b0;
    end
    chk(busy === 1'b0, "R9", int'(busy), 0);
    chk(done === 1'b1, "R9", int'(done), 1);
    chk(mode === 2'(e_mode), tag, int'(mode), e_mode);
    chk(pkt  === WORD_W'(e_pkt), tag, int'(pkt), e_pkt);
    chk(thr  === WORD_W'(e_thr), tag, int'(thr), e_thr);
    chk(err  === 1'(e_err), tag, int'(err), e_err);
    @(negedge clk);
    chk(done === 1'b0, "R9", int'(done), 0);
    chk(mode === 2'(e_mode) && thr === WORD_W'(e_thr), "R10", int'(thr), e_thr);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL R9: watchdog expired, actual busy %0d expected 0", busy);
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0 && err === 1'b0, "R10", int'(busy), 0);
    chk(mode === 2'd0 && pkt === '0 && thr === '0, "R10", int'(thr), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy === 1'b0, "R10", int'(busy), 0);

    run_case(0, 0, 200, 5, 0);    // R3 element
    run_case(2, 1, 64, 32, 0);    // R2 invalid format
    run_case(3, 0, 64, 32, 0);    // R2 invalid with threshold off
    run_case(0, 1, 64, 32, 0);    // R4 words == max
    run_case(1, 1, 256, 16, 0);   // R2 32-bit, R6 pkt 16
    run_case(0, 1, 60, 7, 0);     // R6 30/7 -> pkt 6
    run_case(0, 1, 56, 9, 0);     // R6 28/9 -> pkt 7
    run_case(0, 1, 44, 4, 0);     // R5 long walk, pkt 2
    run_case(0, 1, 26, 4, 0);     // R7 prime 13
    run_case(0, 1, 10, 0, 0);     // R8 zero threshold
    run_case(0, 1, 0, 0, 0);      // R4 zero words
    run_case(0, 1, 12, 1, 0);     // R7 initial divider equals words
    run_case(0, 1, 61, 7, 0);     // R2 odd byte truncation
    run_case(0, 1, 2047, 1023, 0);// R4 full range
    run_case(1, 1, 2047, 100, 0); // R2 511 words
    run_case(0, 1, 2042, 2, 0);   // R7 1021 words, long search
    run_case(0, 1, 44, 4, 1);     // R1 ignored start during search
    run_case(0, 0, 200, 5, 1);    // R1 ignored start during classification
    for (int w = 1; w <= 40; w++)
      for (int m = 1; m <= 8; m++)
        run_case(0, 1, 2 * w, m, 0);

    repeat (2) @(negedge clk);
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule